// File: doc/BRIEF.md
# Two-Line-Enable OTP Memory Bus Model

This block is a synthesizable, clocked stand-in for a byte-wide one-time-programmable memory as seen from its pins. It is meant as a target for testbenches or as a memory emulator. Each clock edge samples the chip-enable line, the output-enable line and the program-voltage qualifier that shares it, a high-voltage flag on one address pin, the address bus and the input data. From these it picks one of six modes: standby, program inhibit, output disable, read, identification or program. Levels that are analog on real pins are flags here. Tri-state is explicit: the block has a data bus, a drive-enable and a data-valid flag.

Access times are counted in clock edges. Data appears only after the address and chip enable have both been steady for `ACC_CYC` sampled edges, and output enable has been low for `OE_CYC` edges. An output state machine has three states. `S_FLOAT` means not driving. `S_DRIVEN` means driving, but the access time has not yet elapsed. `S_VALID` means driving with valid data. On each edge the machine takes one of these transitions:

- to_float: the mode is not read or identification, or the output-enable count is short.
- to_driven: the output-enable count is met but the access count is not.
- to_valid: both counts are met.

Every state can reach every state in one edge.

Storage is a register array of `2**STORE_AW` bytes, erased to all ones. Program mode can only clear bits.

Top module: `otp_bus_model`

## Requirements
- R1: In read mode (`ce_n`=0, `oe_n`=0, `vpp_hi`=0, not identification), once the timing of R8 is met, `dout` carries the byte stored at `addr[STORE_AW-1:0]`, with `dout_en`=1 and `dout_valid`=1.
- R2: With `ce_n`=0, `oe_n`=1 and `vpp_hi`=0 sampled at an edge, `dout_en` and `dout_valid` are 0 after that edge.
- R3: With `ce_n`=1 and `vpp_hi`=0 sampled, the outputs float after that edge, whatever `oe_n`, `hv_flag` or `addr` hold, and storage is unchanged.
- R4: With `ce_n`=0 and `vpp_hi`=1 sampled, the addressed cell becomes its old value AND `din` at that edge, and the outputs float.
- R5: With `ce_n`=1 and `vpp_hi`=1 sampled, nothing is written and the outputs float.
- R6: Identification applies when `ce_n`=0, `oe_n`=0, `vpp_hi`=0, `hv_flag`=1, and every address bit other than bit 0 and bit `HV_BIT` (9) is 0. In that mode `dout` is 8'h1E when `addr[0]`=0 and 8'h0D when `addr[0]`=1, under the same timing as R1. If `hv_flag`=1 and any other address bit is set, the access is an ordinary read.
- R7: Reset sets every cell to 8'hFF and clears `dout`, `dout_en` and `dout_valid`.
- R8: The access count is 0 at an edge with `ce_n`=1. It is 1 at the first edge with `ce_n`=0 after a high, or after `addr` or `hv_flag` differs from the previous edge. Otherwise it increments, saturating at `ACC_CYC`. The output-enable count works the same way on `oe_n`=0 with `vpp_hi`=0. `dout_en` rises when the output-enable count reaches `OE_CYC` in read or identification mode. `dout_valid` additionally needs the access count at `ACC_CYC`. An address change therefore drops `dout_valid` at the next edge.
- R9: `dout` is 8'h00 whenever `dout_valid` is 0, and `dout_valid` never rises without `dout_en`.
- R10: Address bits at and above `STORE_AW` do not select storage, so addresses that differ only there reach the same cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_hi | input | 1 | Program voltage present on the output-enable line |
| hv_flag | input | 1 | High voltage present on address pin `HV_BIT` |
| addr | input | ADDR_W (16) | Byte address |
| din | input | DATA_W (8) | Program data |
| dout | output | DATA_W (8) | Read data, zero when not valid |
| dout_en | output | 1 | Data bus driven |
| dout_valid | output | 1 | Data on `dout` is valid |

## Verification
The bench targets the following corner cases:

- An address change in the middle of a valid read. A design with nonzero hold would keep `dout_valid` high on the stale byte.
- Enabling output before the access time expires. A design that skipped `S_DRIVEN` would raise valid early, or stay floating too long.
- The high-voltage flag arriving with a stray address bit set. A loose identification decode would return 8'h1E or 8'h0D in place of the stored byte.
- Repeated programming of the same cell, and programming through an aliased address. An overwriting array would set bits back to one, and a full-width index would miss the alias.
- Program voltage with chip enable high. This must write nothing, and any write would show up on a later read.

// File: rtl/otp_pkg.sv
package otp_pkg;
    typedef enum logic [2:0] {
        M_STBY,
        M_INHIBIT,
        M_ODIS,
        M_READ,
        M_IDENT,
        M_PROG
    } otp_mode_e;

    typedef enum logic [1:0] {
        S_FLOAT,
        S_DRIVEN,
        S_VALID
    } out_state_e;
endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int HV_BIT = 9
) (
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              hv_flag,
    input  logic [ADDR_W-1:0] addr,
    output otp_mode_e         mode
);
    localparam logic [ADDR_W-1:0] ID_FREE = (ADDR_W'(1) << HV_BIT) | ADDR_W'(1);

    logic id_addr_ok;
    assign id_addr_ok = hv_flag && ((addr & ~ID_FREE) == '0);

    always_comb begin
        if (ce_n) begin
            mode = vpp_hi ? M_INHIBIT : M_STBY;
        end else if (vpp_hi) begin
            mode = M_PROG;
        end else if (oe_n) begin
            mode = M_ODIS;
        end else if (id_addr_ok) begin
            mode = M_IDENT;
        end else begin
            mode = M_READ;
        end
    end
endmodule

// File: rtl/otp_delay_track.sv
module otp_delay_track #(
    parameter int ADDR_W  = 16,
    parameter int ACC_CYC = 4,
    parameter int OE_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_act,
    input  logic              hv_flag,
    input  logic [ADDR_W-1:0] addr,
    output logic              acc_done,
    output logic              oe_done
);
    localparam int AW_C = $clog2(ACC_CYC + 1);
    localparam int OW_C = $clog2(OE_CYC + 1);
    localparam logic [AW_C-1:0] ACC_MAX = AW_C'(ACC_CYC);
    localparam logic [OW_C-1:0] OE_MAX  = OW_C'(OE_CYC);

    logic [AW_C-1:0]   acc_q, acc_nx;
    logic [OW_C-1:0]   oe_q, oe_nx;
    logic              ce_n_q, hv_q, oe_act_q;
    logic [ADDR_W-1:0] addr_q;
    logic              restart;

    assign restart = ce_n_q || (addr != addr_q) || (hv_flag != hv_q);

    always_comb begin
        if (ce_n)                 acc_nx = '0;
        else if (restart)         acc_nx = AW_C'(1);
        else if (acc_q < ACC_MAX) acc_nx = acc_q + AW_C'(1);
        else                      acc_nx = acc_q;

        if (!oe_act)              oe_nx = '0;
        else if (!oe_act_q)       oe_nx = OW_C'(1);
        else if (oe_q < OE_MAX)   oe_nx = oe_q + OW_C'(1);
        else                      oe_nx = oe_q;
    end

    assign acc_done = (acc_nx >= ACC_MAX);
    assign oe_done  = (oe_nx >= OE_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            oe_q     <= '0;
            ce_n_q   <= 1'b1;
            hv_q     <= 1'b0;
            oe_act_q <= 1'b0;
            addr_q   <= '0;
        end else begin
            acc_q    <= acc_nx;
            oe_q     <= oe_nx;
            ce_n_q   <= ce_n;
            hv_q     <= hv_flag;
            oe_act_q <= oe_act;
            addr_q   <= addr;
        end
    end

    // R8: a chip-enable fall or an address change never counts as a completed access
    generate
        if (ACC_CYC > 1) begin : g_acc_chk
            a_r8_restart_not_done: assert property (@(posedge clk) disable iff (!rst_n)
                (!ce_n && (ce_n_q || addr != addr_q)) |-> !acc_done);
        end
    endgenerate
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
    parameter int DATA_W   = 8,
    parameter int STORE_AW = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [STORE_AW-1:0] cell_addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata
);
    localparam int DEPTH = 1 << STORE_AW;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (wr_en) begin
            cells[cell_addr] <= cells[cell_addr] & wdata;
        end
    end

    assign rdata = cells[cell_addr];

    // R4: a programmed cell never gains a one
    a_r4_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((cells[$past(cell_addr)] & ~$past(rdata)) == '0));
endmodule

// File: rtl/otp_bus_model.sv
module otp_bus_model
    import otp_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter int          STORE_AW = 10,
    parameter int          HV_BIT   = 9,
    parameter int          ACC_CYC  = 4,
    parameter int          OE_CYC   = 2,
    parameter logic [7:0]  ID_MFR   = 8'h1E,
    parameter logic [7:0]  ID_DEV   = 8'h0D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              hv_flag,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              dout_valid
);
    otp_mode_e         mode;
    out_state_e        state_q, state_nx;
    logic              acc_done, oe_done, out_mode;
    logic [DATA_W-1:0] cell_rd, byte_sel, dout_q;

    otp_mode_decode #(.ADDR_W(ADDR_W), .HV_BIT(HV_BIT)) u_dec (
        .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi), .hv_flag(hv_flag),
        .addr(addr), .mode(mode)
    );

    otp_delay_track #(.ADDR_W(ADDR_W), .ACC_CYC(ACC_CYC), .OE_CYC(OE_CYC)) u_trk (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_act(!oe_n && !vpp_hi),
        .hv_flag(hv_flag), .addr(addr), .acc_done(acc_done), .oe_done(oe_done)
    );

    otp_cell_array #(.DATA_W(DATA_W), .STORE_AW(STORE_AW)) u_arr (
        .clk(clk), .rst_n(rst_n), .wr_en(mode == M_PROG),
        .cell_addr(addr[STORE_AW-1:0]), .wdata(din), .rdata(cell_rd)
    );

    assign out_mode = (mode == M_READ) || (mode == M_IDENT);

    always_comb begin
        if (mode == M_IDENT) byte_sel = DATA_W'(addr[0] ? ID_DEV : ID_MFR);
        else                 byte_sel = cell_rd;
    end

    always_comb begin
        state_nx = S_FLOAT;
        unique case (state_q)
            S_FLOAT, S_DRIVEN, S_VALID: begin
                if (!out_mode || !oe_done) state_nx = S_FLOAT;
                else if (!acc_done)        state_nx = S_DRIVEN;
                else                       state_nx = S_VALID;
            end
            default: state_nx = S_FLOAT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_FLOAT;
            dout_q  <= '0;
        end else begin
            state_q <= state_nx;
            dout_q  <= (state_nx == S_VALID) ? byte_sel : '0;
        end
    end

    always_comb begin
        unique case (state_q)
            S_FLOAT:  begin dout_en = 1'b0; dout_valid = 1'b0; end
            S_DRIVEN: begin dout_en = 1'b1; dout_valid = 1'b0; end
            S_VALID:  begin dout_en = 1'b1; dout_valid = 1'b1; end
            default:  begin dout_en = 1'b0; dout_valid = 1'b0; end
        endcase
    end
    assign dout = dout_q;

    // R3, R5: chip enable high leaves the bus floating
    a_r3_standby_float: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_n) |-> !dout_en);
    // R2, R4: output enable high or program voltage floats the bus
    a_r2_disable_float: assert property (@(posedge clk) disable iff (!rst_n)
        $past(oe_n || vpp_hi) |-> !dout_en);
    // R9: valid data only while driving, zero data otherwise
    a_r9_valid_needs_drive: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> dout_en);
    a_r9_zero_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_valid |-> (dout == '0));
endmodule

// File: tb/otp_bus_model_bench.sv
module otp_bus_model_bench;
    localparam int ACC = 4;
    localparam int OEC = 2;
    localparam int SAW = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, hv_flag = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en, dout_valid;

    int total = 0, bad = 0;
    logic [7:0] mm [1 << SAW];
    int  m_acc, m_oe;
    bit  p_ce, p_hv, p_oeact;
    logic [15:0] p_addr;
    bit  e_en, e_val;
    logic [7:0] e_d;
    int  e_mode;

    always #2.5 clk = ~clk;

    otp_bus_model u_otp_bus_model (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
        .hv_flag(hv_flag), .addr(addr), .din(din), .dout(dout),
        .dout_en(dout_en), .dout_valid(dout_valid)
    );

    // 0 stby 1 inhibit 2 odis 3 read 4 ident 5 prog
    function automatic int mode_of();
        if (ce_n) return vpp_hi ? 1 : 0;
        if (vpp_hi) return 5;
        if (oe_n) return 2;
        if (hv_flag && ((addr & ~16'h0201) == 16'h0)) return 4;
        return 3;
    endfunction

    function automatic string tag_of(int m);
        case (m)
            0: return "R3";
            1: return "R5";
            2: return "R2";
            3: return "R1";
            4: return "R6";
            default: return "R4";
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < (1 << SAW); i++) mm[i] = 8'hFF;
        m_acc = 0; m_oe = 0; p_ce = 1; p_hv = 0; p_oeact = 0; p_addr = '0;
    endtask

    task automatic check(string tag);
        total++;
        if (dout_en !== e_en || dout_valid !== e_val || dout !== e_d) begin
            bad++;
            $display("FAIL %s en=%b valid=%b dout=%h expected en=%b valid=%b dout=%h",
                     tag, dout_en, dout_valid, dout, e_en, e_val, e_d);
        end
    endtask

    task automatic step(string hint);
        bit oeact;
        @(posedge clk);
        e_mode = mode_of();
        oeact = !oe_n && !vpp_hi;
        if (ce_n) m_acc = 0;
        else if (p_ce || addr != p_addr || hv_flag != p_hv) m_acc = 1;
        else if (m_acc < ACC) m_acc++;
        if (!oeact) m_oe = 0;
        else if (!p_oeact) m_oe = 1;
        else if (m_oe < OEC) m_oe++;
        e_en  = (e_mode == 3 || e_mode == 4) && m_oe >= OEC;
        e_val = e_en && m_acc >= ACC;
        if (!e_val) e_d = 8'h00;
        else if (e_mode == 4) e_d = addr[0] ? 8'h0D : 8'h1E;
        else e_d = mm[addr[SAW-1:0]];
        if (e_mode == 5) mm[addr[SAW-1:0]] &= din;
        p_ce = ce_n; p_hv = hv_flag; p_oeact = oeact; p_addr = addr;
        #1;
        check(hint != "" ? hint : (!e_val ? {tag_of(e_mode), "/R9"} : tag_of(e_mode)));
    endtask

    task automatic drive(bit c, bit o, bit v, bit h, logic [15:0] a, logic [7:0] d);
        ce_n = c; oe_n = o; vpp_hi = v; hv_flag = h; addr = a; din = d;
    endtask

    task automatic hold(int n, string hint);
        for (int i = 0; i < n; i++) step(hint);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int seed;
        seed = $urandom(32'd20240611);
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        e_en = 0; e_val = 0; e_d = 8'h00;
        check("R7 reset outputs");
        @(negedge clk); rst_n = 1'b1;

        // R7: erased cells read as all ones, R8 timing covered by per-edge checks
        drive(0, 0, 0, 0, 16'h0005, 8'h00); hold(6, "R7 erased read");
        // R2 output disable then R3 standby with oe low
        drive(0, 1, 0, 0, 16'h0005, 8'h00); hold(2, "R2");
        drive(1, 0, 0, 1, 16'h0201, 8'h00); hold(2, "R3");
        // R4 program, twice on same cell: bits only clear
        drive(0, 1, 1, 0, 16'h0005, 8'hA5); hold(1, "R4");
        drive(0, 1, 1, 0, 16'h0005, 8'h3C); hold(1, "R4");
        // R5 inhibit: no write
        drive(1, 1, 1, 0, 16'h0006, 8'h00); hold(2, "R5");
        drive(0, 0, 0, 0, 16'h0006, 8'h00); hold(6, "R5 cell unchanged");
        // R10 alias: 0x0405 reaches cell 5 (expect 8'h24)
        drive(0, 0, 0, 0, 16'h0405, 8'h00); hold(6, "R10 alias read");
        // R8 address change mid-read drops valid next edge
        drive(0, 0, 0, 0, 16'h0006, 8'h00); hold(1, "R8 addr change");
        hold(5, "R8 reaccess");
        // R8 oe late: ce low long, oe falls after
        drive(0, 1, 0, 0, 16'h0005, 8'h00); hold(6, "R8 oe late");
        drive(0, 0, 0, 0, 16'h0005, 8'h00); hold(3, "R8 oe count");
        // R6 identification codes and the stray-bit fallback
        drive(0, 0, 0, 1, 16'h0200, 8'h00); hold(6, "R6 mfr");
        drive(0, 0, 0, 1, 16'h0001, 8'h00); hold(6, "R6 dev");
        drive(0, 0, 0, 1, 16'h0205, 8'h00); hold(6, "R6 stray bit reads cell");

        // constrained random mix
        for (int k = 0; k < 4000; k++) begin
            bit c, o, v, h;
            logic [15:0] a;
            c = ($urandom % 10) < 2;
            o = ($urandom % 10) < 3;
            v = ($urandom % 10) < 1;
            h = ($urandom % 10) < 1;
            a = addr;
            if (($urandom % 10) < 3) begin
                if (h && ($urandom % 2)) a = 16'(($urandom % 2) | (($urandom % 2) << 9));
                else a = 16'($urandom) & 16'h040F;
            end
            if (($urandom % 10) < 6) drive(ce_n, oe_n, vpp_hi, hv_flag, addr, din);
            else drive(c, o, v, h, a, 8'($urandom));
            step("");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule